// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synchronous single-port memory with a pipelined read path and a two-bit burst address sequencer. On every rising clock edge it samples the address, three chip enables, two address strobes, a burst-advance input and the write controls. It classifies the cycle as one of the following:

- a deselect;
- the start of an access at a new external address;
- a step to the next burst address;
- a hold at the current burst address.

Each access is either a read or a write. Read data passes through one output register before it reaches the data-out port. The data bus is modelled as separate `din` and `dout` ports plus an output-drive flag, `dout_en`. The drive flag is further qualified by an asynchronous active-low output enable.

There are two address strobes. The processor strobe has priority over the controller strobe, is gated by the first chip enable, and always opens the access as a read. A write that follows it lands on the next clock. The controller strobe can write in the same clock it presents the address.

The data word is split into byte lanes. Each lane carries 8 data bits with a parity bit above them. Lanes are written either all together under a global write, or one by one under a byte-write enable and per-lane selects. The burst order is linear or interleaved, chosen by a static strap input.

Top module: `psram_burst_ctl`

## Requirements
- R1: When the processor strobe and the controller strobe are both low with `ce1_n` low, only the processor strobe is honoured. The cycle opens a read at `addr`, and no lane is written even if write controls are active.
- R2: While `ce1_n` is high, a low `pstrb_n` has no effect. With `cstrb_n` low the cycle is a deselect. With `cstrb_n` high an open access continues or holds at its burst address.
- R3: A processor-strobe write takes two clocks. On the strobe clock the write controls and `adv_n` are ignored. On the next clock, with both strobes high and `adv_n` high, the write controls and `din` are applied to the captured address.
- R4: With `cstrb_n` low, `pstrb_n` high and the chip selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0), active write controls write `addr` on that same clock.
- R5: A low `gw_n` writes every lane, whatever `bwe_n` and `bsel_n` are.
- R6: With `gw_n` high, lane i (din bits 9i+7..9i as data and bit 9i+8 as its parity bit) is written only when `bwe_n` is low and `bsel_n[i]` is low. Other lanes keep their contents. With `bwe_n` high no lane is written and the cycle is a read.
- R7: The read whose address is registered at edge k appears on `dout` after edge k+1, provided edge k+1 is also a read cycle.
- R8: After a deselect or a write, the first read cycle keeps `dout_en` low whatever `oe_n` is.
- R9: `dout_en` is low after any edge decoded as a write and after any edge decoded as a deselect.
- R10: On a cycle with both strobes high and an access open, `adv_n` low moves to the next burst address and `adv_n` high holds the current one. The two low address bits follow start+k mod 4 when `burst_ilv`=0, or start XOR k when `burst_ilv`=1. The upper address bits stay fixed.
- R11: After reset the block is deselected with `dout_en` low. Cycles without a strobe neither read nor write until a strobe opens an access.
- R12: `dout_en` is low whenever `oe_n` is high, and follows it without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_ilv | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| din | input | LANES*9 | Write data, lane i in bits 9i+8..9i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*9 | Read data, zero when not driven |
| dout_en | output | 1 | Output drive flag |

## Verification
The burst-order property is the only one that depends on how the inputs are driven. It relies on `burst_ilv` staying still while an access is open, and on reset being applied before the first edge. The random stimulus respects both. It changes the strap only right after a forced deselect, and it holds `rst_n` low across the first clocks. All other inputs, including chip enables, strobes and `oe_n`, are drawn freely each cycle so that deselect, priority and masking cases mix with bursts.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int LANE_W = 9;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN_RD,
    CYC_BEGIN_WR,
    CYC_SEQ_RD,
    CYC_SEQ_WR
  } cyc_e;

  // low address bits of burst beat 'step' from a start offset
  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

  function automatic logic cyc_is_write(input cyc_e c);
    return (c == CYC_BEGIN_WR) || (c == CYC_SEQ_WR);
  endfunction

  function automatic logic cyc_is_read(input cyc_e c);
    return (c == CYC_BEGIN_RD) || (c == CYC_SEQ_RD);
  endfunction

  function automatic logic cyc_is_begin(input cyc_e c);
    return (c == CYC_BEGIN_RD) || (c == CYC_BEGIN_WR);
  endfunction

  function automatic logic cyc_is_seq(input cyc_e c);
    return (c == CYC_SEQ_RD) || (c == CYC_SEQ_WR);
  endfunction

endpackage

// File: rtl/psram_cycle_dec.sv
module psram_cycle_dec
  import psram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic             active,
  output cyc_e             cyc,
  output logic [LANES-1:0] lane_we
);

  logic             chip_sel;
  logic             p_take;
  logic             c_take;
  logic [LANES-1:0] req_mask;

  assign chip_sel = !ce1_n && ce2 && !ce3_n;
  assign p_take   = !pstrb_n && !ce1_n;
  assign c_take   = !p_take && !cstrb_n;

  // global write overrides the per-lane selects
  assign req_mask = !gw_n ? {LANES{1'b1}}
                  : (!bwe_n ? ~bsel_n : {LANES{1'b0}});

  always_comb begin
    cyc = CYC_IDLE;
    if (p_take) begin
      cyc = chip_sel ? CYC_BEGIN_RD : CYC_DESEL;
    end else if (c_take) begin
      if (!chip_sel)      cyc = CYC_DESEL;
      else if (|req_mask) cyc = CYC_BEGIN_WR;
      else                cyc = CYC_BEGIN_RD;
    end else if (active) begin
      cyc = (|req_mask) ? CYC_SEQ_WR : CYC_SEQ_RD;
    end
  end

  assign lane_we = cyc_is_write(cyc) ? req_mask : {LANES{1'b0}};

endmodule

// File: rtl/psram_burst_ctr.sv
module psram_burst_ctr
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] eff_addr
);

  logic [ADDR_W-3:0] base_q;
  logic [1:0]        start_q;
  logic [1:0]        step_q;
  logic [1:0]        step_nx;

  assign step_nx  = adv ? step_q + 2'd1 : step_q;
  assign eff_addr = load ? ext_addr
                         : {base_q, burst_lsb(start_q, step_nx, ilv)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      step_q  <= '0;
    end else if (load) begin
      base_q  <= ext_addr[ADDR_W-1:2];
      start_q <= ext_addr[1:0];
      step_q  <= '0;
    end else if (adv) begin
      step_q  <= step_nx;
    end
  end

  // a step keeps the upper address bits and changes the lane offset
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && $stable(ilv) && $past(rst_n) && !$past(load))
      |-> (eff_addr[1:0] != $past(eff_addr[1:0]))
        || (eff_addr[ADDR_W-1:2] != $past(eff_addr[ADDR_W-1:2])))
    else $error("burst step did not move"); // R10

endmodule

// File: rtl/psram_lane_array.sv
module psram_lane_array
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      rd_load,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we[g]) cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    // output pipeline register, loaded from the address registered last edge
    always_ff @(posedge clk) begin
      if (rd_load) q <= cells[rd_addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/psram_burst_ctl.sv
module psram_burst_ctl
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     burst_ilv,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     pstrb_n,
  input  logic                     cstrb_n,
  input  logic                     adv_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [LANES-1:0]         bsel_n,
  input  logic [LANES*LANE_W-1:0]  din,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  cyc_e              cyc;
  logic [LANES-1:0]  lane_we;
  logic              load_now;
  logic              adv_step;
  logic              rd_now;
  logic              wr_now;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] rdata;

  logic              active_q;
  logic              rd_pipe_q;
  logic              valid_q;
  logic [ADDR_W-1:0] rd_addr_q;

  psram_cycle_dec #(.LANES(LANES)) dec_i (
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .pstrb_n (pstrb_n),
    .cstrb_n (cstrb_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bsel_n  (bsel_n),
    .active  (active_q),
    .cyc     (cyc),
    .lane_we (lane_we)
  );

  assign load_now = cyc_is_begin(cyc);
  assign adv_step = cyc_is_seq(cyc) && !adv_n;
  assign rd_now   = cyc_is_read(cyc);
  assign wr_now   = cyc_is_write(cyc);

  psram_burst_ctr #(.ADDR_W(ADDR_W)) ctr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_now),
    .adv      (adv_step),
    .ilv      (burst_ilv),
    .ext_addr (addr),
    .eff_addr (eff_addr)
  );

  psram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) mem_i (
    .clk     (clk),
    .we      (lane_we),
    .wr_addr (eff_addr),
    .wdata   (din),
    .rd_load (rd_pipe_q),
    .rd_addr (rd_addr_q),
    .rdata   (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      rd_pipe_q <= 1'b0;
      valid_q   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (cyc == CYC_DESEL) active_q <= 1'b0;
      else if (load_now)    active_q <= 1'b1;
      rd_pipe_q <= rd_now;
      // drive only when the previous edge also registered a read
      valid_q   <= rd_now && rd_pipe_q;
      if (rd_now) rd_addr_q <= eff_addr;
    end
  end

  assign dout_en = valid_q && !oe_n;
  assign dout    = dout_en ? rdata : '0;

  AST_PSTRB_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstrb_n && !ce1_n) |-> (lane_we == '0))
    else $error("write during processor strobe cycle"); // R1

  AST_CSTRB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstrb_n && pstrb_n && !ce1_n && ce2 && !ce3_n && !gw_n) |-> (lane_we != '0))
    else $error("controller strobe write not same clock"); // R4

  AST_GW_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && !gw_n) |-> (&lane_we))
    else $error("global write missed a lane"); // R5

  AST_FIRST_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && load_now && !active_q) |=> !dout_en)
    else $error("first read after deselect driven"); // R8

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> !dout_en)
    else $error("outputs driven after write"); // R9

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |=> !dout_en)
    else $error("outputs driven after deselect"); // R9

endmodule

// File: tb/psram_burst_ctl_tb.sv
module psram_burst_ctl_tb_top;

  localparam int AW    = 6;
  localparam int LN    = 4;
  localparam int DW    = LN * 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          burst_ilv = 1'b0;
  logic          ce1_n, ce2, ce3_n, pstrb_n, cstrb_n, adv_n;
  logic [AW-1:0] addr;
  logic          gw_n, bwe_n;
  logic [LN-1:0] bsel_n;
  logic [DW-1:0] din;
  logic          oe_n;
  logic [DW-1:0] dout;
  logic          dout_en;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  psram_burst_ctl #(.ADDR_W(AW), .LANES(LN)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_ilv(burst_ilv),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .addr(addr),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .din(din),
    .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  // reference model state
  logic [DW-1:0] refmem [DEPTH];
  bit            m_active = 0, m_rdpipe = 0, m_valid = 0;
  logic [AW-1:0] m_paddr = '0;
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_start = '0, m_step = '0;
  logic [DW-1:0] m_data = '0;

  function automatic logic [LN-1:0] lanes_hit();
    logic [LN-1:0] r;
    for (int i = 0; i < LN; i++) r[i] = !gw_n || (!bwe_n && !bsel_n[i]);
    return r;
  endfunction

  function automatic logic [1:0] beat(input logic [1:0] s, input logic [1:0] k, input logic il);
    logic [1:0] r;
    if (il) r = {s[1] != k[1], s[0] != k[0]};
    else    r = 2'((int'(s) + int'(k)) % 4);
    return r;
  endfunction

  task automatic idle_in();
    ce1_n = 0; ce2 = 1; ce3_n = 0; pstrb_n = 1; cstrb_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bsel_n = '1; oe_n = 0; addr = '0; din = '0;
  endtask

  task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model one clock edge with the current inputs, then compare after it
  task automatic tick(input string tag);
    bit sel, pt, beg, seq, wr, rd, des, ee;
    logic [LN-1:0] wl;
    logic [AW-1:0] a;
    logic [1:0] st;
    logic [DW-1:0] nd;
    sel = !ce1_n && ce2 && !ce3_n;
    pt  = !pstrb_n && !ce1_n;
    wl  = lanes_hit();
    beg = 0; seq = 0; wr = 0; rd = 0; des = 0;
    if (pt) begin
      if (sel) begin beg = 1; rd = 1; end else des = 1;
    end else if (!cstrb_n) begin
      if (sel) begin beg = 1; wr = |wl; rd = !wr; end else des = 1;
    end else if (m_active) begin
      seq = 1; wr = |wl; rd = !wr;
    end
    st = (seq && !adv_n) ? m_step + 2'd1 : m_step;
    a  = beg ? addr : {m_base, beat(m_start, st, burst_ilv)};
    nd = refmem[m_paddr];
    if (wr)
      for (int i = 0; i < LN; i++)
        if (wl[i]) refmem[a][i*9 +: 9] = din[i*9 +: 9];
    if (m_rdpipe) m_data = nd;
    m_valid  = rd && m_rdpipe;
    m_rdpipe = rd;
    if (rd) m_paddr = a;
    if (des) m_active = 0;
    if (beg) begin
      m_active = 1; m_base = addr[AW-1:2]; m_start = addr[1:0]; m_step = '0;
    end else if (seq) m_step = st;
    @(posedge clk);
    @(negedge clk);
    ee = m_valid && !oe_n;
    nchk++;
    if (dout_en !== ee || (ee && dout !== m_data)) begin
      nfail++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
               tag, dout_en, dout, ee, m_data);
    end
  endtask

  task automatic rd_begin(input logic [AW-1:0] a, input string tag);
    idle_in(); cstrb_n = 0; addr = a; tick(tag);
  endtask

  task automatic force_desel(input string tag);
    idle_in(); ce1_n = 1; cstrb_n = 0; tick(tag);
  endtask

  logic [DW-1:0] d1, d2, old9, old10, old12;

  initial begin
    void'($urandom(32'd4177));
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R11: reset state, strobeless cycles do nothing
    chk("R11 reset dout_en", {1'b0, DW'(dout_en)}, '0);
    idle_in(); tick("R11");
    idle_in(); adv_n = 0; gw_n = 0; tick("R11");

    // fill memory with global writes, lane controls inactive (R5)
    for (int a = 0; a < DEPTH; a++) begin
      idle_in(); cstrb_n = 0; gw_n = 0; bwe_n = 1; bsel_n = '1;
      addr = AW'(a); din = DW'({$urandom(), $urandom()});
      tick("R5");
    end
    force_desel("R9");
    rd_begin(AW'(7), "R8");
    idle_in(); tick("R5");
    chk("R5 all lanes written", {1'b0, dout}, {1'b0, refmem[7]});

    // R10 linear burst from 5: 5,6,7,4 then hold
    force_desel("R9");
    burst_ilv = 0;
    rd_begin(AW'(5), "R8");
    chk("R8 first read masked", {1'b0, DW'(dout_en)}, '0);
    idle_in(); adv_n = 0; tick("R7");
    chk("R7 latency", {1'b0, dout}, {1'b0, refmem[5]});
    idle_in(); adv_n = 0; tick("R10");
    chk("R10 linear beat1", {1'b0, dout}, {1'b0, refmem[6]});
    idle_in(); adv_n = 0; tick("R10");
    chk("R10 linear beat2", {1'b0, dout}, {1'b0, refmem[7]});
    idle_in(); tick("R10");
    chk("R10 linear wrap", {1'b0, dout}, {1'b0, refmem[4]});
    idle_in(); tick("R10");
    chk("R10 hold", {1'b0, dout}, {1'b0, refmem[4]});

    // R12: output enable is asynchronous
    oe_n = 1; #1;
    chk("R12 oe high", {1'b0, DW'(dout_en)}, '0);
    oe_n = 0; #1;
    chk("R12 oe low", {1'b0, DW'(dout_en)}, {1'b0, DW'(1)});

    // R10 interleaved burst from 14: 14,15,12,13
    force_desel("R9");
    burst_ilv = 1;
    rd_begin(AW'(14), "R8");
    idle_in(); adv_n = 0; tick("R10");
    idle_in(); adv_n = 0; tick("R10");
    chk("R10 ilv beat1", {1'b0, dout}, {1'b0, refmem[15]});
    idle_in(); adv_n = 0; tick("R10");
    chk("R10 ilv beat2", {1'b0, dout}, {1'b0, refmem[12]});
    idle_in(); tick("R10");
    chk("R10 ilv beat3", {1'b0, dout}, {1'b0, refmem[13]});
    burst_ilv = 0;

    // R6 byte lanes: lanes 1 and 3 written at 9; bwe high leaves 10 alone
    old9 = refmem[9]; old10 = refmem[10];
    d1 = DW'({$urandom(), $urandom()});
    idle_in(); cstrb_n = 0; addr = AW'(9); bwe_n = 0; bsel_n = 4'b0101; din = d1;
    tick("R6");
    idle_in(); cstrb_n = 0; addr = AW'(10); bwe_n = 1; bsel_n = 4'b0000;
    din = ~old10; tick("R6");
    rd_begin(AW'(9), "R6");
    idle_in(); tick("R6");
    chk("R6 lane merge", {1'b0, dout},
        {1'b0, d1[35:27], old9[26:18], d1[17:9], old9[8:0]});
    rd_begin(AW'(10), "R6");
    idle_in(); tick("R6");
    chk("R6 bwe high no write", {1'b0, dout}, {1'b0, old10});

    // R1: both strobes with global write -> read, no write
    old12 = refmem[12];
    force_desel("R9");
    idle_in(); pstrb_n = 0; cstrb_n = 0; gw_n = 0; addr = AW'(12); din = ~old12;
    tick("R1");
    idle_in(); tick("R1");
    chk("R1 priority read", {1'b0, dout}, {1'b0, old12});

    // R3: processor strobe write lands on next clock at the captured address
    d2 = DW'({$urandom(), $urandom()});
    force_desel("R9");
    idle_in(); pstrb_n = 0; addr = AW'(20); gw_n = 0; adv_n = 0; din = ~d2;
    tick("R3");
    idle_in(); gw_n = 0; din = d2; tick("R3");
    chk("R3 write hiz", {1'b0, DW'(dout_en)}, '0);
    d1 = refmem[21];
    rd_begin(AW'(20), "R3");
    idle_in(); adv_n = 0; tick("R3");
    chk("R3 data at captured addr", {1'b0, dout}, {1'b0, d2});
    idle_in(); tick("R3");
    chk("R3 next addr untouched", {1'b0, dout}, {1'b0, d1});

    // R4: controller strobe write then immediate read
    d1 = DW'({$urandom(), $urandom()});
    idle_in(); cstrb_n = 0; gw_n = 0; addr = AW'(40); din = d1; tick("R4");
    rd_begin(AW'(40), "R4");
    idle_in(); tick("R4");
    chk("R4 single clock write", {1'b0, dout}, {1'b0, d1});

    // R2: ce1 high with processor strobe is ignored; burst holds at 33
    rd_begin(AW'(33), "R2");
    idle_in(); ce1_n = 1; pstrb_n = 0; addr = AW'(50); tick("R2");
    idle_in(); tick("R2");
    chk("R2 strobe ignored", {1'b0, dout}, {1'b0, refmem[33]});
    idle_in(); ce1_n = 1; pstrb_n = 0; cstrb_n = 0; tick("R2");
    chk("R2 deselect", {1'b0, DW'(dout_en)}, '0);

    // random segments, strap changes only after a deselect
    for (int s = 0; s < 40; s++) begin
      force_desel("R9");
      burst_ilv = $urandom() % 2;
      for (int c = 0; c < 40; c++) begin
        ce1_n   = ($urandom() % 8) == 0;
        ce2     = ($urandom() % 10) != 0;
        ce3_n   = ($urandom() % 10) == 0;
        pstrb_n = ($urandom() % 5) != 0;
        cstrb_n = ($urandom() % 4) != 0;
        adv_n   = $urandom() % 2;
        gw_n    = ($urandom() % 7) != 0;
        bwe_n   = ($urandom() % 3) != 0;
        bsel_n  = LN'($urandom());
        oe_n    = ($urandom() % 6) == 0;
        addr    = AW'($urandom());
        din     = DW'({$urandom(), $urandom()});
        tick("RAND-R7-R10");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule